// File: doc/BRIEF.md
# Security Mode Controller

This block tracks the protection state of a processor across three modes: open, secure-entry and secure. It always comes out of reset in open mode. A strobe from boot software moves it into secure-entry, where the signature check firmware runs. An external verifier reports a pass or a fail. A pass moves the block into secure mode; a fail sends it back to open mode. While in secure-entry, the block watches every valid program-counter value. Any fetch outside the firmware ROM window aborts the attempt at once.

The block drives three protection outputs. One blocks DMA into internal memory. One enables the private emulation port. One enables access to the private one-time-programmable area. In open mode these outputs are forced to their unrestricted values. In secure-entry they are forced to their restricted values. In secure mode they come from a switch register that authenticated software may rewrite. The emulation enable can be granted for the current secure session only, or persistently, so that it survives the exit from secure mode. The public test-port functions, such as boundary scan and bypass, stay enabled in every mode.

Top module: `secmode_ctrl`

## Requirements
- R1: After a synchronous reset the block is in open mode with these output values: `mode`=0, `dma_block`=0, `priv_emu_en`=1, `otp_priv_en`=0 and `auth_fail`=0.
- R2: The mode encoding is 0 for open, 1 for secure-entry and 2 for secure. If `auth_req` is high in open mode, the mode reads 1 in the next cycle.
- R3: In secure-entry mode, `dma_block`=1 and `otp_priv_en`=0. `priv_emu_en` is high only if the persistent emulation enable is set.
- R4: In secure-entry mode, a cycle with `pc_valid` high and `pc` outside the inclusive range [ROM_LO, ROM_HI] returns the block to open mode in the next cycle. In that same next cycle `auth_fail` pulses high for one cycle. This excursion check takes precedence over an `auth_done` in the same cycle. A `pc` equal to ROM_LO or ROM_HI does not abort.
- R5: In secure-entry mode, `auth_done` with `auth_pass`=1 moves the block to secure mode in the next cycle. `auth_done` with `auth_pass`=0 moves it to open mode and pulses `auth_fail`.
- R6: On entry to secure mode, `otp_priv_en`=1, `dma_block`=1 and the session emulation enable is cleared. A `sw_we` in secure mode loads `sw_wdata` into the switch register, and the new values appear in the next cycle. The fields are: bit 0 for DMA block, bit 1 for session emulation enable and bit 2 for persistent emulation enable. `priv_emu_en` is the OR of the two emulation bits.
- R7: A `sw_we` in open or secure-entry mode has no effect. For example, a persistent-enable write made in open mode leaves `priv_emu_en`=0 in the following secure-entry mode.
- R8: `exit_req` in secure mode returns the block to open mode in the next cycle. It clears the session emulation and DMA-block bits and keeps the persistent emulation bit. That bit then holds `priv_emu_en` high in a later secure-entry mode.
- R9: `pub_jtag_en` is 1 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auth_req | input | 1 | Request to start authentication |
| auth_done | input | 1 | Verifier result strobe |
| auth_pass | input | 1 | Verifier result, 1 = signature good |
| pc | input | PC_W | Program counter |
| pc_valid | input | 1 | `pc` carries a fetched address |
| exit_req | input | 1 | Leave secure mode |
| sw_we | input | 1 | Switch register write strobe |
| sw_wdata | input | 3 | Switch write data: bit 0 DMA block, bit 1 session emu, bit 2 persistent emu |
| mode | output | 2 | Current mode (0 open, 1 secure-entry, 2 secure) |
| auth_fail | output | 1 | One-cycle pulse on an aborted or failed authentication |
| dma_block | output | 1 | Block DMA into internal memory |
| priv_emu_en | output | 1 | Private emulation enable |
| otp_priv_en | output | 1 | Private OTP access enable |
| pub_jtag_en | output | 1 | Public test-port functions enable |

## Verification
The hardest state to reach is a persistent emulation grant that is seen outside secure mode. To get there, the stimulus passes a full authentication and writes the persistent bit in secure mode. It then exits and starts a second authentication, and finally checks the emulation enable during secure-entry. The window checks need the block to be held in secure-entry while fetches land exactly on the two bounds and one step past each. The bench then starts a fresh attempt for each excursion. A further case puts an excursion and a passing result in the same cycle, to show that the abort takes precedence.

// File: rtl/secmode_pkg.sv
package secmode_pkg;
    typedef enum logic [1:0] {
        MODE_OPEN   = 2'd0,
        MODE_ENTRY  = 2'd1,
        MODE_SECURE = 2'd2
    } mode_t;

    typedef struct packed {
        logic emu_persist;
        logic emu_session;
        logic dma_block;
    } switch_t;

    localparam int SW_W = $bits(switch_t);

    function automatic switch_t sw_reset_value(input logic keep_persist);
        switch_t s;
        s.emu_persist = keep_persist;
        s.emu_session = 1'b0;
        s.dma_block   = 1'b0;
        return s;
    endfunction
endpackage

// File: rtl/secmode_pc_watch.sv
module secmode_pc_watch #(
    parameter int PC_W = 16,
    parameter logic [PC_W-1:0] ROM_LO = 16'h1000,
    parameter logic [PC_W-1:0] ROM_HI = 16'h1FFF
) (
    input  logic [PC_W-1:0] pc,
    input  logic            pc_valid,
    output logic            excursion
);
    logic in_window;

    always_comb begin
        in_window = (pc >= ROM_LO) && (pc <= ROM_HI);
        excursion = pc_valid && !in_window;
    end
endmodule

// File: rtl/secmode_fsm.sv
module secmode_fsm
    import secmode_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  auth_req,
    input  logic  auth_done,
    input  logic  auth_pass,
    input  logic  excursion,
    input  logic  exit_req,
    output mode_t mode,
    output logic  auth_fail,
    output logic  enter_sec,
    output logic  leave_sec
);
    mode_t mode_nxt;
    logic  fail_nxt;

    always_comb begin
        mode_nxt  = mode;
        fail_nxt  = 1'b0;
        enter_sec = 1'b0;
        leave_sec = 1'b0;
        unique case (mode)
            MODE_OPEN: begin
                if (auth_req) mode_nxt = MODE_ENTRY;
            end
            MODE_ENTRY: begin
                if (excursion) begin
                    mode_nxt = MODE_OPEN;
                    fail_nxt = 1'b1;
                end else if (auth_done) begin
                    if (auth_pass) begin
                        mode_nxt  = MODE_SECURE;
                        enter_sec = 1'b1;
                    end else begin
                        mode_nxt = MODE_OPEN;
                        fail_nxt = 1'b1;
                    end
                end
            end
            MODE_SECURE: begin
                if (exit_req) begin
                    mode_nxt  = MODE_OPEN;
                    leave_sec = 1'b1;
                end
            end
            default: mode_nxt = MODE_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= MODE_OPEN;
            auth_fail <= 1'b0;
        end else begin
            mode      <= mode_nxt;
            auth_fail <= fail_nxt;
        end
    end

    p_reset_open_r1: assert property (@(posedge clk) rst |=> (mode == MODE_OPEN) && !auth_fail);

    p_request_entry_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OPEN && auth_req) |=> mode == MODE_ENTRY);

    p_excursion_abort_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_ENTRY && excursion) |=> (mode == MODE_OPEN) && auth_fail);

    p_pass_secure_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_ENTRY && !excursion && auth_done && auth_pass) |=> mode == MODE_SECURE);

    p_exit_open_r8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SECURE && exit_req) |=> mode == MODE_OPEN);
endmodule

// File: rtl/secmode_switches.sv
module secmode_switches
    import secmode_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  mode_t           mode,
    input  logic            enter_sec,
    input  logic            leave_sec,
    input  logic            sw_we,
    input  logic [SW_W-1:0] sw_wdata,
    output logic            dma_block,
    output logic            priv_emu_en,
    output logic            otp_priv_en
);
    switch_t sw;

    always_ff @(posedge clk) begin
        if (rst) begin
            sw <= sw_reset_value(1'b0);
        end else if (enter_sec) begin
            sw           <= sw_reset_value(sw.emu_persist);
            sw.dma_block <= 1'b1;
        end else if (leave_sec) begin
            sw <= sw_reset_value(sw.emu_persist);
        end else if (mode == MODE_SECURE && sw_we) begin
            sw <= switch_t'(sw_wdata);
        end
    end

    always_comb begin
        unique case (mode)
            MODE_ENTRY: begin
                dma_block   = 1'b1;
                priv_emu_en = sw.emu_persist;
                otp_priv_en = 1'b0;
            end
            MODE_SECURE: begin
                dma_block   = sw.dma_block;
                priv_emu_en = sw.emu_session | sw.emu_persist;
                otp_priv_en = 1'b1;
            end
            default: begin
                dma_block   = 1'b0;
                priv_emu_en = 1'b1;
                otp_priv_en = 1'b0;
            end
        endcase
    end

    p_open_unrestricted_r1: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OPEN) |-> !dma_block && !otp_priv_en && priv_emu_en);

    p_entry_locked_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_ENTRY) |-> dma_block && !otp_priv_en);

    p_secure_defaults_r6: assert property (@(posedge clk) disable iff (rst)
        enter_sec |=> dma_block && otp_priv_en && !sw.emu_session);

    p_ignored_write_r7: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_SECURE && !enter_sec) |=> $stable(sw));

    p_persist_kept_r8: assert property (@(posedge clk) disable iff (rst)
        leave_sec |=> sw.emu_persist == $past(sw.emu_persist));
endmodule

// File: rtl/secmode_ctrl.sv
module secmode_ctrl
    import secmode_pkg::*;
#(
    parameter int PC_W = 16,
    parameter logic [PC_W-1:0] ROM_LO = 16'h1000,
    parameter logic [PC_W-1:0] ROM_HI = 16'h1FFF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            auth_req,
    input  logic            auth_done,
    input  logic            auth_pass,
    input  logic [PC_W-1:0] pc,
    input  logic            pc_valid,
    input  logic            exit_req,
    input  logic            sw_we,
    input  logic [2:0]      sw_wdata,
    output logic [1:0]      mode,
    output logic            auth_fail,
    output logic            dma_block,
    output logic            priv_emu_en,
    output logic            otp_priv_en,
    output logic            pub_jtag_en
);
    mode_t mode_q;
    logic  excursion;
    logic  enter_sec;
    logic  leave_sec;

    secmode_pc_watch #(.PC_W(PC_W), .ROM_LO(ROM_LO), .ROM_HI(ROM_HI)) u_watch (
        .pc        (pc),
        .pc_valid  (pc_valid),
        .excursion (excursion)
    );

    secmode_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .auth_req  (auth_req),
        .auth_done (auth_done),
        .auth_pass (auth_pass),
        .excursion (excursion),
        .exit_req  (exit_req),
        .mode      (mode_q),
        .auth_fail (auth_fail),
        .enter_sec (enter_sec),
        .leave_sec (leave_sec)
    );

    secmode_switches u_sw (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode_q),
        .enter_sec   (enter_sec),
        .leave_sec   (leave_sec),
        .sw_we       (sw_we),
        .sw_wdata    (sw_wdata),
        .dma_block   (dma_block),
        .priv_emu_en (priv_emu_en),
        .otp_priv_en (otp_priv_en)
    );

    assign mode        = mode_q;
    assign pub_jtag_en = 1'b1;
endmodule

// File: tb/secmode_ctrl_test.sv
module secmode_ctrl_test;
    localparam logic [15:0] LO = 16'h1000;
    localparam logic [15:0] HI = 16'h1FFF;

    logic clk = 1'b0;
    logic rst, auth_req, auth_done, auth_pass, pc_valid, exit_req, sw_we;
    logic [15:0] pc;
    logic [2:0]  sw_wdata;
    logic [1:0]  mode;
    logic auth_fail, dma_block, priv_emu_en, otp_priv_en, pub_jtag_en;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    secmode_ctrl #(.PC_W(16), .ROM_LO(LO), .ROM_HI(HI)) uut (
        .clk(clk), .rst(rst), .auth_req(auth_req), .auth_done(auth_done),
        .auth_pass(auth_pass), .pc(pc), .pc_valid(pc_valid), .exit_req(exit_req),
        .sw_we(sw_we), .sw_wdata(sw_wdata), .mode(mode), .auth_fail(auth_fail),
        .dma_block(dma_block), .priv_emu_en(priv_emu_en), .otp_priv_en(otp_priv_en),
        .pub_jtag_en(pub_jtag_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        auth_req = 0; auth_done = 0; auth_pass = 0; pc_valid = 0;
        exit_req = 0; sw_we = 0; sw_wdata = 3'b000; pc = LO;
    endtask

    // apply current inputs for one edge, then sample at the next falling edge
    task automatic cycle();
        @(negedge clk);
        idle();
    endtask

    task automatic outs(input string tag, input int m, input int f, input int d, input int e, input int o);
        chk({tag, " mode"}, mode, m);
        chk({tag, " auth_fail"}, auth_fail, f);
        chk({tag, " dma_block"}, dma_block, d);
        chk({tag, " priv_emu_en"}, priv_emu_en, e);
        chk({tag, " otp_priv_en"}, otp_priv_en, o);
        chk({tag, " pub_jtag_en R9"}, pub_jtag_en, 1);
    endtask

    task automatic do_reset();
        rst = 1; idle();
        @(negedge clk); @(negedge clk);
        rst = 0;
    endtask

    task automatic go_entry();
        auth_req = 1; cycle();
    endtask

    task automatic go_secure();
        go_entry();
        auth_done = 1; auth_pass = 1; cycle();
    endtask

    task automatic t_reset();
        do_reset();
        outs("R1 reset", 0, 0, 0, 1, 0);
    endtask

    task automatic t_entry();
        go_entry();
        outs("R2 R3 entry", 1, 0, 1, 0, 0);
        pc_valid = 1; pc = LO; cycle();
        outs("R4 pc at low bound", 1, 0, 1, 0, 0);
        pc_valid = 1; pc = HI; cycle();
        outs("R4 pc at high bound", 1, 0, 1, 0, 0);
        pc_valid = 0; pc = 16'h0000; cycle();
        outs("R4 invalid pc ignored", 1, 0, 1, 0, 0);
        pc_valid = 1; pc = HI + 16'd1; cycle();
        outs("R4 above high bound", 0, 1, 0, 1, 0);
        cycle();
        chk("R4 fail pulse one cycle", auth_fail, 0);
        go_entry();
        pc_valid = 1; pc = LO - 16'd1; cycle();
        outs("R4 below low bound", 0, 1, 0, 1, 0);
    endtask

    task automatic t_priority();
        go_entry();
        pc_valid = 1; pc = 16'hF000; auth_done = 1; auth_pass = 1; cycle();
        outs("R4 excursion beats pass", 0, 1, 0, 1, 0);
    endtask

    task automatic t_result();
        go_entry();
        auth_done = 1; auth_pass = 0; cycle();
        outs("R5 failed result", 0, 1, 0, 1, 0);
        go_secure();
        outs("R5 R6 secure defaults", 2, 0, 1, 0, 1);
    endtask

    task automatic t_writes();
        sw_we = 1; sw_wdata = 3'b010; cycle();
        outs("R6 session emu, dma off", 2, 0, 0, 1, 1);
        sw_we = 1; sw_wdata = 3'b001; cycle();
        outs("R6 dma on, emu off", 2, 0, 1, 0, 1);
        exit_req = 1; cycle();
        outs("R8 exit", 0, 0, 0, 1, 0);
        go_entry();
        outs("R8 session emu not kept", 1, 0, 1, 0, 0);
        sw_we = 1; sw_wdata = 3'b110; cycle();
        chk("R7 write in entry ignored", priv_emu_en, 0);
        auth_done = 1; auth_pass = 1; cycle();
        chk("R7 entry write not in secure", priv_emu_en, 0);
    endtask

    task automatic t_persist();
        do_reset();
        sw_we = 1; sw_wdata = 3'b100; cycle();
        go_entry();
        chk("R7 open write ignored", priv_emu_en, 0);
        auth_done = 1; auth_pass = 1; cycle();
        sw_we = 1; sw_wdata = 3'b100; cycle();
        outs("R6 persistent emu", 2, 0, 0, 1, 1);
        exit_req = 1; cycle();
        go_entry();
        outs("R8 R3 persistent kept in entry", 1, 0, 1, 1, 0);
        auth_done = 1; auth_pass = 1; cycle();
        outs("R8 persistent in new session", 2, 0, 1, 1, 1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_entry();
                t_priority();
                t_result();
                t_writes();
                t_persist();
            end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule